// File: doc/BRIEF.md
# Serial EEPROM Slave Command Controller

This block is the two-wire serial slave front end of a 1024-byte byte-addressable memory. The memory is split into 8 blocks of 128 bytes, and each block holds 8 pages of 16 bytes. The controller runs on a system clock and oversamples the serial clock and data lines through synchronisers. It recognises START and STOP conditions and matches the device address byte. For writes it takes a word address and stages up to one page of data bytes. For reads it returns bytes from the current address. It pulls the data line low through an open-drain enable whenever it acknowledges or sends a zero bit.

Staged write data is programmed only after STOP. A timed write cycle copies the staged bytes into the array one per clock. While that cycle runs, the device does not answer its own address. A write-protect input blocks programming but still lets a write command load the address. A separate permit input carries the decision of an outside protection policy. An active-low protect-reset input holds the serial logic idle while it is low.

Top module: `eep_i2c_slave_ctrl`

## Requirements
- R1: After reset the data-line pull-down `sda_oe` is 0, and the controller drives nothing until a START is seen.
- R2: Only address bytes whose upper five bits are 10101 get an ACK (A8h–AFh, bit 0 = 1 for read). Any other address byte, for example A0h or B8h, gets no ACK.
- R3: On a write, bits [2:1] of the address byte form memory address bits [9:8] and the word-address byte forms bits [7:0]. A byte written there reads back unchanged.
- R4: During a write only address bits [3:0] advance. After offset 15 of a page the next byte lands at offset 0 of the same page, and the neighbouring page is not touched.
- R5: A 17th data byte in one write gets no ACK. No byte of that transfer is programmed, and no write cycle starts.
- R6: Programming starts only at STOP and lasts WR_CYCLES clocks. During that time the address byte gets no ACK; after it ends, the address byte is acknowledged again.
- R7: During a read only address bits [6:0] advance, so the address wraps from the last byte of a 128-byte block to the first byte of that same block.
- R8: The block bits [2:1] of a read address byte are ignored. A read uses the block that the last word address loaded.
- R9: With `wp` high at STOP nothing is programmed and no write cycle starts. The word address is still loaded, and a following current-address read uses it.
- R10: With `wr_allow` low, data bytes of a write get no ACK and are not programmed. The address byte and the word address are still acknowledged.
- R11: While `prot_n` is low the serial logic is held idle and `sda_oe` is 0. After `prot_n` returns high the controller waits for a new START.
- R12: A NACK from the master after a read byte ends the read. The data line then stays released until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_n | input | 1 | Active-low protect reset; holds the serial logic idle while low |
| wp | input | 1 | Write protect; when high, a write is not programmed |
| wr_allow | input | 1 | Policy permit for data writes; when low, data bytes get NACK |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull the data line low when 1 |

## Verification
Writes are run in several forms: a single byte, a run that crosses the end of a page, a 17-byte overflow, a write made with protect high, and a write denied by the permit input. Reading back what was programmed separates page wrap, dropped transfers and refused transfers. Reads are run as random, current-address and sequential reads that cross the end of a block, with block bits that differ from the latched block. This tells block wrap apart from linear increment, and latched block bits apart from the bits sent with the read. Addressing the device right after a STOP separates a write cycle that really started from one that was skipped. A byte clocked after a master NACK, or after a protect-reset pulse, shows whether the data line was released.

// File: rtl/eep_pkg.sv
package eep_pkg;

    localparam int BYTE_W        = 8;
    localparam int PAGE_BYTES    = 16;
    localparam int PAGES_PER_BLK = 8;
    localparam int BLOCKS        = 8;
    localparam int BLK_BYTES     = PAGE_BYTES * PAGES_PER_BLK;
    localparam int MEM_BYTES     = BLK_BYTES * BLOCKS;
    localparam int ADDR_W        = $clog2(MEM_BYTES);
    localparam int PAGE_W        = $clog2(PAGE_BYTES);
    localparam int BLK_W         = $clog2(BLK_BYTES);
    localparam int SEL_W         = ADDR_W - BYTE_W;
    localparam int CNT_W         = $clog2(PAGE_BYTES + 1);

    localparam logic [4:0] DEV_TAG = 5'b10101;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] mem_addr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_WAIT
    } ser_state_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_WADDR,
        K_WDATA
    } rx_kind_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } line_ev_t;

    // write pointer: page offset rolls over, page number is kept
    function automatic mem_addr_t wr_next(input mem_addr_t a);
        return {a[ADDR_W-1:PAGE_W], a[PAGE_W-1:0] + PAGE_W'(1)};
    endfunction

    // read pointer: block offset rolls over, block number is kept
    function automatic mem_addr_t rd_next(input mem_addr_t a);
        return {a[ADDR_W-1:BLK_W], a[BLK_W-1:0] + BLK_W'(1)};
    endfunction

endpackage

// File: rtl/eep_line_sampler.sv
module eep_line_sampler
    import eep_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_q;
    logic                   sda_q;
    logic                   scl_s;
    logic                   sda_s;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= scl_i;
                    sda_sync <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
                    sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_sync[SYNC_STAGES-1];
    assign sda_s = sda_sync[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
        ev.sda      = sda_s;
    end

endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int DEPTH = 1024,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/eep_write_timer.sv
module eep_write_timer #(
    parameter int WR_CYCLES = 64,
    parameter int SLOTS     = 16,
    localparam int CW       = $clog2(WR_CYCLES + 1),
    localparam int IW       = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    output logic          busy,
    output logic          slot_valid,
    output logic [IW-1:0] slot_idx
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (go) begin
                busy <= 1'b1;
                cnt  <= '0;
            end
        end else begin
            cnt <= cnt + CW'(1);
            if (cnt == CW'(WR_CYCLES - 1)) begin
                busy <= 1'b0;
            end
        end
    end

    assign slot_valid = busy && (cnt < CW'(SLOTS));
    assign slot_idx   = cnt[IW-1:0];

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < CW'(WR_CYCLES))); // R6

endmodule

// File: rtl/eep_i2c_slave_ctrl.sv
module eep_i2c_slave_ctrl
    import eep_pkg::*;
#(
    parameter int WR_CYCLES   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic prot_n,
    input  logic wp,
    input  logic wr_allow,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int PAGE_NUM_W = ADDR_W - PAGE_W;

    line_ev_t               ev;
    ser_state_e             st;
    rx_kind_e               kind;
    logic [2:0]             bitcnt;
    logic                   byte_full;
    byte_t                  shreg;
    byte_t                  txreg;
    logic                   rw;
    logic                   mack;
    logic [SEL_W-1:0]       dev_blk;
    mem_addr_t              addr;
    byte_t                  rdata;

    // staged page write
    logic                   sess_open;
    logic                   sess_drop;
    logic [CNT_W-1:0]       sess_cnt;
    byte_t                  pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0]  pmask;
    logic [PAGE_NUM_W-1:0]  commit_page;
    logic                   commit_go;

    // programming cycle
    logic                   wr_busy;
    logic                   slot_valid;
    logic [PAGE_W-1:0]      slot_idx;
    logic                   mem_we;

    eep_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    eep_write_timer #(.WR_CYCLES(WR_CYCLES), .SLOTS(PAGE_BYTES)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .go         (commit_go),
        .busy       (wr_busy),
        .slot_valid (slot_valid),
        .slot_idx   (slot_idx)
    );

    assign mem_we = slot_valid && pmask[slot_idx];

    eep_store #(.DEPTH(MEM_BYTES), .DW(BYTE_W)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr ({commit_page, slot_idx}),
        .wdata (pbuf[slot_idx]),
        .raddr (addr),
        .rdata (rdata)
    );

    always_ff @(posedge clk) begin
        commit_go <= 1'b0;
        if (rst) begin
            st          <= ST_IDLE;
            kind        <= K_DEV;
            bitcnt      <= '0;
            byte_full   <= 1'b0;
            shreg       <= '0;
            txreg       <= '0;
            rw          <= 1'b0;
            mack        <= 1'b0;
            sda_oe      <= 1'b0;
            sess_open   <= 1'b0;
            sess_drop   <= 1'b0;
            sess_cnt    <= '0;
            dev_blk     <= '0;
            addr        <= '0;
            pmask       <= '0;
            commit_page <= '0;
        end else if (!prot_n) begin
            st        <= ST_IDLE;
            kind      <= K_DEV;
            bitcnt    <= '0;
            byte_full <= 1'b0;
            sda_oe    <= 1'b0;
            sess_open <= 1'b0;
            sess_drop <= 1'b0;
            sess_cnt  <= '0;
        end else if (ev.start) begin
            st        <= ST_RX;
            kind      <= K_DEV;
            bitcnt    <= '0;
            byte_full <= 1'b0;
            sda_oe    <= 1'b0;
            sess_open <= 1'b0;
        end else if (ev.stop) begin
            if (sess_open && !sess_drop && (sess_cnt != '0) && !wp) begin
                commit_go   <= 1'b1;
                commit_page <= addr[ADDR_W-1:PAGE_W];
            end
            st        <= ST_IDLE;
            sda_oe    <= 1'b0;
            sess_open <= 1'b0;
        end else begin
            unique case (st)
                ST_RX: begin
                    if (ev.scl_rise) begin
                        shreg  <= {shreg[BYTE_W-2:0], ev.sda};
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) byte_full <= 1'b1;
                    end else if (ev.scl_fall && byte_full) begin
                        byte_full <= 1'b0;
                        bitcnt    <= '0;
                        unique case (kind)
                            K_DEV: begin
                                if (shreg[7:3] == DEV_TAG && !wr_busy) begin
                                    rw     <= shreg[0];
                                    sda_oe <= 1'b1;
                                    st     <= ST_ACK;
                                    if (!shreg[0]) dev_blk <= shreg[SEL_W:1];
                                end else begin
                                    st <= ST_WAIT;
                                end
                            end
                            K_WADDR: begin
                                addr      <= {dev_blk, shreg};
                                sess_open <= 1'b1;
                                sess_drop <= 1'b0;
                                sess_cnt  <= '0;
                                pmask     <= '0;
                                sda_oe    <= 1'b1;
                                st        <= ST_ACK;
                            end
                            default: begin
                                if (sess_cnt == CNT_W'(PAGE_BYTES) || !wr_allow) begin
                                    sess_drop <= 1'b1;
                                    st        <= ST_WAIT;
                                end else begin
                                    pbuf[addr[PAGE_W-1:0]]  <= shreg;
                                    pmask[addr[PAGE_W-1:0]] <= 1'b1;
                                    addr     <= wr_next(addr);
                                    sess_cnt <= sess_cnt + CNT_W'(1);
                                    sda_oe   <= 1'b1;
                                    st       <= ST_ACK;
                                end
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (ev.scl_fall) begin
                        if (kind == K_DEV && rw) begin
                            txreg  <= rdata;
                            addr   <= rd_next(addr);
                            sda_oe <= ~rdata[BYTE_W-1];
                            bitcnt <= '0;
                            st     <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            kind   <= (kind == K_DEV) ? K_WADDR : K_WDATA;
                            st     <= ST_RX;
                        end
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        if (bitcnt == 3'd7) begin
                            sda_oe <= 1'b0;
                            st     <= ST_MACK;
                        end else begin
                            txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~txreg[BYTE_W-2];
                            bitcnt <= bitcnt + 3'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.scl_rise) begin
                        mack <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        if (mack) begin
                            txreg  <= rdata;
                            addr   <= rd_next(addr);
                            sda_oe <= ~rdata[BYTE_W-1];
                            bitcnt <= '0;
                            st     <= ST_TX;
                        end else begin
                            st <= ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE || st == ST_WAIT) |-> !sda_oe); // R1

    AST_PROT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !prot_n |=> (!sda_oe && st == ST_IDLE)); // R11

    AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACK && kind == K_DEV) |-> !wr_busy); // R6

    AST_PROGRAM_IN_CYCLE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> wr_busy); // R6

    AST_PAGE_COUNT_MAX: assert property (@(posedge clk) disable iff (rst)
        sess_cnt <= CNT_W'(PAGE_BYTES)); // R5

    AST_WRITE_PAGE_FIXED: assert property (@(posedge clk) disable iff (rst)
        (sess_open && $past(sess_open)) |-> $stable(addr[ADDR_W-1:PAGE_W])); // R4

    AST_READ_BLOCK_FIXED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_TX && $past(st) == ST_MACK) |->
            (addr[ADDR_W-1:BLK_W] == $past(addr[ADDR_W-1:BLK_W]))); // R7

    AST_MNACK_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && $past(st) == ST_MACK) |-> !sda_oe); // R12

endmodule

// File: tb/eep_i2c_slave_ctrl_tb_top.sv
module eep_i2c_slave_ctrl_tb_top;

    localparam int WRC = 1000;
    localparam int Q   = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic prot_n = 1'b1;
    logic wp = 1'b0;
    logic wr_allow = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    wire  sda_line = sda_m & ~sda_oe;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;
    logic [7:0] wbuf [20];
    logic [7:0] rbuf [20];

    always #4 clk = ~clk;

    eep_i2c_slave_ctrl #(.WR_CYCLES(WRC), .SYNC_STAGES(2)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .prot_n   (prot_n),
        .wp       (wp),
        .wr_allow (wr_allow),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe)
    );

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic i2c_start;
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic i2c_stop;
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b1; hold(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hold(Q);
            scl_m = 1'b1; hold(2 * Q);
            scl_m = 1'b0; hold(Q);
        end
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        ack = !sda_line; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit give_ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hold(Q);
            scl_m = 1'b1; hold(Q);
            b[i] = sda_line; hold(Q);
            scl_m = 1'b0; hold(Q);
        end
        sda_m = !give_ack; hold(Q);
        scl_m = 1'b1; hold(2 * Q);
        scl_m = 1'b0; hold(Q);
        sda_m = 1'b1;
    endtask

    // nack_at: -1 all acked, -3 address refused, -2 word refused, else data index
    task automatic wr_xfer(input logic [1:0] blk, input logic [7:0] word,
                           input int n, output int nack_at);
        bit a;
        nack_at = -1;
        i2c_start;
        send_byte({5'b10101, blk, 1'b0}, a);
        if (!a) nack_at = -3;
        else begin
            send_byte(word, a);
            if (!a) nack_at = -2;
            else begin
                for (int i = 0; i < n; i++) begin
                    send_byte(wbuf[i], a);
                    if (!a) begin
                        nack_at = i;
                        break;
                    end
                end
            end
        end
        i2c_stop;
    endtask

    task automatic rd_tail(input logic [1:0] rd_blk, input int n, output bit dev_ack);
        send_byte({5'b10101, rd_blk, 1'b1}, dev_ack);
        if (dev_ack) begin
            for (int i = 0; i < n; i++) recv_byte(rbuf[i], i != n - 1);
        end
        i2c_stop;
    endtask

    task automatic rd_rand(input logic [1:0] blk, input logic [7:0] word,
                           input logic [1:0] rd_blk, input int n, output bit ok);
        bit a1, a2, a3;
        i2c_start;
        send_byte({5'b10101, blk, 1'b0}, a1);
        send_byte(word, a2);
        i2c_start;
        rd_tail(rd_blk, n, a3);
        ok = a1 && a2 && a3;
    endtask

    task automatic rd_cur(input logic [1:0] rd_blk, input int n, output bit ok);
        i2c_start;
        rd_tail(rd_blk, n, ok);
    endtask

    task automatic wait_cycle;
        hold(WRC + 50);
    endtask

    task automatic t_reset;
        chk("R1", "sda_oe after reset", int'(sda_oe), 0);
        hold(20);
        chk("R1", "line idle without START", int'(sda_line), 1);
    endtask

    task automatic t_addr_match;
        bit a;
        logic [7:0] b;
        i2c_start; send_byte(8'hA0, a); i2c_stop;
        chk("R2", "A0h refused", int'(a), 0);
        i2c_start; send_byte(8'hB8, a); i2c_stop;
        chk("R2", "B8h refused", int'(a), 0);
        i2c_start; send_byte(8'hAB, a);
        chk("R2", "ABh acknowledged", int'(a), 1);
        if (a) recv_byte(b, 1'b0);
        i2c_stop;
    endtask

    task automatic t_byte_write;
        int na;
        bit ok;
        wbuf[0] = 8'h5A;
        wr_xfer(2'd2, 8'h35, 1, na);
        chk("R3", "single write acks", na, -1);
        wait_cycle;
        rd_rand(2'd2, 8'h35, 2'd2, 1, ok);
        chk("R3", "read acks", int'(ok), 1);
        chk("R3", "readback 0x235", int'(rbuf[0]), 'h5A);
    endtask

    task automatic t_page_wrap;
        int na;
        bit ok;
        wbuf[0] = 8'h77;
        wr_xfer(2'd1, 8'h50, 1, na);
        wait_cycle;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        wr_xfer(2'd1, 8'h4E, 4, na);
        chk("R4", "wrapping write acks", na, -1);
        wait_cycle;
        rd_rand(2'd1, 8'h4E, 2'd1, 3, ok);
        chk("R4", "0x14E", int'(rbuf[0]), 'h11);
        chk("R4", "0x14F", int'(rbuf[1]), 'h22);
        chk("R4", "next page 0x150 untouched", int'(rbuf[2]), 'h77);
        rd_rand(2'd1, 8'h40, 2'd1, 2, ok);
        chk("R4", "wrapped 0x140", int'(rbuf[0]), 'h33);
        chk("R4", "wrapped 0x141", int'(rbuf[1]), 'h44);
    endtask

    task automatic t_overflow;
        int na;
        bit ok, a;
        wbuf[0] = 8'hC3;
        wr_xfer(2'd0, 8'h20, 1, na);
        wait_cycle;
        for (int i = 0; i < 17; i++) wbuf[i] = 8'(i);
        wr_xfer(2'd0, 8'h20, 17, na);
        chk("R5", "17th byte refused", na, 16);
        i2c_start; send_byte(8'hA0 | 8'h08, a); i2c_stop;
        chk("R5", "no write cycle after overflow", int'(a), 1);
        rd_rand(2'd0, 8'h20, 2'd0, 1, ok);
        chk("R5", "0x020 unchanged", int'(rbuf[0]), 'hC3);
    endtask

    task automatic t_busy;
        int na;
        bit a, ok;
        wbuf[0] = 8'h9E;
        wr_xfer(2'd3, 8'h10, 1, na);
        i2c_start; send_byte(8'hAE, a); i2c_stop;
        chk("R6", "address refused during write cycle", int'(a), 0);
        wait_cycle;
        i2c_start; send_byte(8'hAE, a); i2c_stop;
        chk("R6", "address acked after write cycle", int'(a), 1);
        rd_rand(2'd3, 8'h10, 2'd3, 1, ok);
        chk("R6", "0x310 programmed", int'(rbuf[0]), 'h9E);
    endtask

    task automatic t_read_wrap;
        int na;
        bit ok;
        for (int i = 0; i < 16; i++) wbuf[i] = 8'(8'hA0 + i);
        wr_xfer(2'd1, 8'hF0, 16, na);
        chk("R7", "full page write acks", na, -1);
        wait_cycle;
        wbuf[0] = 8'h5C; wbuf[1] = 8'h6D;
        wr_xfer(2'd1, 8'h80, 2, na);
        wait_cycle;
        rd_rand(2'd1, 8'hFE, 2'd1, 3, ok);
        chk("R7", "0x1FE", int'(rbuf[0]), 'hAE);
        chk("R7", "0x1FF", int'(rbuf[1]), 'hAF);
        chk("R7", "wrap to 0x180", int'(rbuf[2]), 'h5C);
    endtask

    task automatic t_block_ignore;
        bit ok;
        rd_rand(2'd1, 8'h80, 2'd3, 1, ok);
        chk("R8", "read with block bits 3 uses block 1", int'(rbuf[0]), 'h5C);
        rd_cur(2'd0, 1, ok);
        chk("R8", "current read with block bits 0", int'(ok), 1);
        chk("R8", "current read 0x181", int'(rbuf[0]), 'h6D);
    endtask

    task automatic t_wp;
        int na;
        bit a, ok;
        wp = 1'b1;
        wbuf[0] = 8'h00;
        wr_xfer(2'd2, 8'h35, 1, na);
        chk("R9", "protected write still acked", na, -1);
        i2c_start; send_byte(8'hAC, a); i2c_stop;
        chk("R9", "no write cycle with wp", int'(a), 1);
        wr_xfer(2'd2, 8'h35, 0, na);
        rd_cur(2'd0, 1, ok);
        chk("R9", "address loaded, data kept", int'(rbuf[0]), 'h5A);
        wp = 1'b0;
    endtask

    task automatic t_deny;
        int na;
        bit ok;
        wr_allow = 1'b0;
        wbuf[0] = 8'h11;
        wr_xfer(2'd2, 8'h35, 1, na);
        chk("R10", "denied data byte refused", na, 0);
        wr_allow = 1'b1;
        wait_cycle;
        rd_rand(2'd2, 8'h35, 2'd2, 1, ok);
        chk("R10", "0x235 unchanged", int'(rbuf[0]), 'h5A);
    endtask

    task automatic t_prot;
        int na;
        bit a;
        logic [7:0] b;
        wbuf[0] = 8'h00; wbuf[1] = 8'h00;
        wr_xfer(2'd3, 8'h00, 2, na);
        wait_cycle;
        i2c_start; send_byte(8'hAE, a); send_byte(8'h00, a);
        i2c_start; send_byte(8'hAF, a);
        chk("R11", "read address acked", int'(a), 1);
        hold(Q); scl_m = 1'b1; hold(Q);
        chk("R11", "first bit driven low", int'(sda_line), 0);
        hold(Q); scl_m = 1'b0; hold(Q);
        prot_n = 1'b0; hold(4);
        chk("R11", "line released in protect reset", int'(sda_line), 1);
        prot_n = 1'b1; hold(4);
        recv_byte(b, 1'b0);
        chk("R11", "idle after protect reset", int'(b), 'hFF);
        i2c_stop;
    endtask

    task automatic t_mnack;
        bit a;
        logic [7:0] b;
        i2c_start; send_byte(8'hAE, a); send_byte(8'h00, a);
        i2c_start; send_byte(8'hAF, a);
        recv_byte(b, 1'b0);
        chk("R12", "byte before NACK", int'(b), 'h00);
        recv_byte(b, 1'b0);
        chk("R12", "released after master NACK", int'(b), 'hFF);
        i2c_stop;
    endtask

    initial begin
        hold(5);
        rst = 1'b0;
        hold(5);
        t_reset;
        t_addr_match;
        t_byte_write;
        t_page_wrap;
        t_overflow;
        t_busy;
        t_read_wrap;
        t_block_ignore;
        t_wp;
        t_deny;
        t_prot;
        t_mnack;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule